// File: doc/BRIEF.md
# Quadrature Position and Revolution Counter

This block turns the two phase signals and the index pulse of a rotary or linear position encoder into a signed 16-bit position count and a 16-bit revolution count. It can also run as a plain up/down event counter, where one input counts up and another counts down. All three inputs are asynchronous to the block clock and pass through a two-flop synchronizer before edge detection.

A small write-only register port sets the configuration: the operating mode, the active edge for each input, the compare values and counter preloads. Two compare registers watch the counters, one for the position count and one for the revolution count. Each raises a sticky match flag that software clears with a register write. Reads come straight from the output ports.

Top module: `qpc_top`

## Requirements
- R1: After reset, the position and revolution counts are 0, both match flags are 0, the direction output shows up (1), and the mode is stopped.
- R2: The configuration register (offset 0) holds the edge selects: A in bits [1:0], B in bits [3:2], Z in bits [5:4]. Each one is coded 00 none, 01 rising, 10 falling, 11 both edges, and each input is set on its own.
- R3: A change on an input shows in the counters at the third rising clock edge after it is sampled, and not before.
- R4: Mode bits [7:6] of the configuration register use 00 for stopped, where no counting happens and Z is ignored. The code 01 selects up/down mode: a qualified A edge adds 1 and a qualified B edge subtracts 1. Qualified A and B edges in the same cycle leave the count unchanged.
- R5: In mode 10, the block counts only qualified A edges. The count goes up when the new A level differs from B and down when it is equal, and B edges are ignored. Mode 11 adds qualified B edges, which count up when the new B level equals A and down otherwise. Qualified A and B edges in the same cycle are ignored in mode 11.
- R6: In any mode except stopped, a qualified Z edge clears the position count. It also steps the revolution count by +1 or -1, following the direction of the latest count step (the step in the same cycle wins).
- R7: A write to offset 1 loads the position count, and a write to offset 2 loads the revolution count. A load takes priority over counting in the same cycle.
- R8: Offset 3 holds the position compare value and offset 4 the revolution compare value. A flag sets when a counting event (a step or a Z clear for position, a Z edge for revolution) leaves the counter equal to its compare value. A load by register write never sets a flag.
- R9: Match flags are sticky. A write to offset 5 with bit 0 set clears the position flag, and with bit 1 set clears the revolution flag. A write of zero changes nothing, and a set in the same cycle wins over a clear.
- R10: Both counters wrap modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Phase A / count-up event input |
| b_i | input | 1 | Phase B / count-down event input |
| z_i | input | 1 | Index input |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register offset |
| wr_data_i | input | 16 | Register write data |
| pos_o | output | 16 | Position count |
| rev_o | output | 16 | Revolution count |
| dir_up_o | output | 1 | Direction of the latest step, 1 = up |
| pos_match_o | output | 1 | Sticky position compare flag |
| rev_match_o | output | 1 | Sticky revolution compare flag |

## Verification
The bench drives full forward and reverse quadrature cycles with both-edge selects. A wrong phase rule would show up as a position that moves the wrong way or only partly returns. It also drives simultaneous A and B changes, which a careless decoder counts as a step. Z edges are applied after reversal and at the zero boundary, where a revolution count that ignores the direction, or wraps wrongly, ends at the wrong value. The compare flags are checked for stickiness, for zero-data clear writes and for preloads landing on the compare value, where a level comparator would set the flag falsely. The latency is sampled one cycle early to catch a missing or extra synchronizer stage.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    MODE_STOP    = 2'b00,
    MODE_UPDN    = 2'b01,
    MODE_QUAD_A  = 2'b10,
    MODE_QUAD_AB = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e     mode;
    edge_sel_e z_sel;
    edge_sel_e b_sel;
    edge_sel_e a_sel;
  } cfg_t;

  localparam int unsigned CFG_W        = $bits(cfg_t);
  localparam int unsigned ADDR_CFG     = 0;
  localparam int unsigned ADDR_POS     = 1;
  localparam int unsigned ADDR_REV     = 2;
  localparam int unsigned ADDR_CMP_POS = 3;
  localparam int unsigned ADDR_CMP_REV = 4;
  localparam int unsigned ADDR_FLAGCLR = 5;
endpackage

// File: rtl/qpc_edge.sv
module qpc_edge
  import qpc_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      raw_i,
  input  edge_sel_e sel_i,
  output logic      level_o,
  output logic      hit_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [1:0]        sel_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign sel_bits = sel_i;
  assign level_o  = sync_q[STAGES-1];
  assign hit_o    = (level_o & ~prev_q & sel_bits[0]) | (~level_o & prev_q & sel_bits[1]);

  AST_NO_DOUBLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_RISE && hit_o) |=> !hit_o); // R2
endmodule

// File: rtl/qpc_step.sv
module qpc_step
  import qpc_pkg::*;
(
  input  mode_e mode_i,
  input  logic  a_hit_i,
  input  logic  b_hit_i,
  input  logic  a_lvl_i,
  input  logic  b_lvl_i,
  output logic  step_o,
  output logic  up_o
);
  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (mode_i)
      MODE_UPDN: begin
        step_o = a_hit_i ^ b_hit_i;
        up_o   = a_hit_i;
      end
      MODE_QUAD_A: begin
        step_o = a_hit_i;
        up_o   = a_lvl_i ^ b_lvl_i;
      end
      MODE_QUAD_AB: begin
        step_o = a_hit_i ^ b_hit_i;
        up_o   = a_hit_i ? (a_lvl_i ^ b_lvl_i) : ~(a_lvl_i ^ b_lvl_i);
      end
      default: begin
        step_o = 1'b0;
        up_o   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/qpc_count.sv
module qpc_count
  import qpc_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              up_i,
  input  logic              z_hit_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  pos_o,
  output logic [CNT_W-1:0]  rev_o,
  output logic              dir_up_o,
  output logic              pos_match_o,
  output logic              rev_match_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pos_q, rev_q, cmp_pos_q, cmp_rev_q, pos_d, rev_d;
  logic             dir_q, dir_now, pos_flag_q, rev_flag_q;
  logic             wr_pos, wr_rev, wr_cpos, wr_crev, wr_clr, pos_evt, rev_evt;

  assign wr_pos  = wr_en_i && wr_addr_i == ADDR_W'(ADDR_POS);
  assign wr_rev  = wr_en_i && wr_addr_i == ADDR_W'(ADDR_REV);
  assign wr_cpos = wr_en_i && wr_addr_i == ADDR_W'(ADDR_CMP_POS);
  assign wr_crev = wr_en_i && wr_addr_i == ADDR_W'(ADDR_CMP_REV);
  assign wr_clr  = wr_en_i && wr_addr_i == ADDR_W'(ADDR_FLAGCLR);

  assign dir_now = step_i ? up_i : dir_q;
  assign pos_evt = !wr_pos && (z_hit_i || step_i);
  assign rev_evt = !wr_rev && z_hit_i;

  always_comb begin
    pos_d = pos_q;
    if (wr_pos)       pos_d = wr_data_i;
    else if (z_hit_i) pos_d = '0;
    else if (step_i)  pos_d = up_i ? pos_q + ONE : pos_q - ONE;
    rev_d = rev_q;
    if (wr_rev)       rev_d = wr_data_i;
    else if (z_hit_i) rev_d = dir_now ? rev_q + ONE : rev_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '0;
      rev_q      <= '0;
      cmp_pos_q  <= '0;
      cmp_rev_q  <= '0;
      dir_q      <= 1'b1;
      pos_flag_q <= 1'b0;
      rev_flag_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      rev_q <= rev_d;
      if (step_i)  dir_q     <= up_i;
      if (wr_cpos) cmp_pos_q <= wr_data_i;
      if (wr_crev) cmp_rev_q <= wr_data_i;
      // set wins over clear
      if (pos_evt && pos_d == cmp_pos_q)   pos_flag_q <= 1'b1;
      else if (wr_clr && wr_data_i[0])     pos_flag_q <= 1'b0;
      if (rev_evt && rev_d == cmp_rev_q)   rev_flag_q <= 1'b1;
      else if (wr_clr && wr_data_i[1])     rev_flag_q <= 1'b0;
    end
  end

  assign pos_o       = pos_q;
  assign rev_o       = rev_q;
  assign dir_up_o    = dir_q;
  assign pos_match_o = pos_flag_q;
  assign rev_match_o = rev_flag_q;

  AST_Z_CLEARS_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_hit_i && !wr_pos) |=> pos_q == '0); // R6
  AST_POS_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pos && !z_hit_i) |=> ((pos_q - $past(pos_q)) == ONE || (pos_q - $past(pos_q)) == '1 || pos_q == $past(pos_q))); // R10
  AST_REV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!z_hit_i && !wr_rev) |=> $stable(rev_q)); // R6
  AST_POS_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_flag_q && !(wr_clr && wr_data_i[0])) |=> pos_flag_q); // R9
  AST_REV_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_flag_q && !(wr_clr && wr_data_i[1])) |=> rev_flag_q); // R9
  AST_LOAD_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pos && !pos_flag_q && !z_hit_i) |=> !pos_flag_q); // R8
endmodule

// File: rtl/qpc_top.sv
module qpc_top
  import qpc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              z_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  pos_o,
  output logic [CNT_W-1:0]  rev_o,
  output logic              dir_up_o,
  output logic              pos_match_o,
  output logic              rev_match_o
);
  localparam int unsigned N_IN = 3;

  cfg_t            cfg_q;
  logic [N_IN-1:0] raw, lvl, hit;
  edge_sel_e       sel [N_IN];
  logic            step, up, z_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          cfg_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_CFG))   cfg_q <= cfg_t'(wr_data_i[CFG_W-1:0]);
  end

  assign raw    = {z_i, b_i, a_i};
  assign sel[0] = cfg_q.a_sel;
  assign sel[1] = cfg_q.b_sel;
  assign sel[2] = cfg_q.z_sel;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    qpc_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[i]),
      .sel_i  (sel[i]),
      .level_o(lvl[i]),
      .hit_o  (hit[i])
    );
  end

  qpc_step u_step (
    .mode_i (cfg_q.mode),
    .a_hit_i(hit[0]),
    .b_hit_i(hit[1]),
    .a_lvl_i(lvl[0]),
    .b_lvl_i(lvl[1]),
    .step_o (step),
    .up_o   (up)
  );

  assign z_hit = hit[2] && cfg_q.mode != MODE_STOP;

  qpc_count #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .up_i       (up),
    .z_hit_i    (z_hit),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pos_o      (pos_o),
    .rev_o      (rev_o),
    .dir_up_o   (dir_up_o),
    .pos_match_o(pos_match_o),
    .rev_match_o(rev_match_o)
  );

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_STOP && !wr_en_i) |=> ($stable(pos_o) && $stable(rev_o))); // R4
  AST_UPDN_TIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_UPDN && hit[0] && hit[1]) |-> !step); // R4
endmodule

// File: tb/sim_qpc_top.sv
module sim_qpc_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CNT_W = 16;
  localparam int  ADDR_W = 3;

  typedef struct {
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] rev;
    logic             dir;
    logic             pm;
    logic             rm;
    string            tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a = 0, b = 0, z = 0, wr_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [CNT_W-1:0]  pos, rev;
  logic              dir_up, pm, rm;

  exp_t exp_q[$];
  event chk_ev;
  int   n_cmp = 0, n_bad = 0;

  // model state
  logic [CNT_W-1:0] m_pos = 0, m_rev = 0, m_cpos = 0, m_crev = 0;
  logic             m_dir = 1, m_pm = 0, m_rm = 0;
  logic [7:0]       m_cfg = 0;
  logic             pa = 0, pb = 0, pz = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .z_i(z),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pos_o(pos), .rev_o(rev), .dir_up_o(dir_up),
    .pos_match_o(pm), .rev_match_o(rm)
  );

  function automatic logic qual(logic o, logic n, logic [1:0] s);
    return (n & ~o & s[0]) | (~n & o & s[1]);
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.pos = m_pos; e.rev = m_rev; e.dir = m_dir; e.pm = m_pm; e.rm = m_rm; e.tag = tag;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (pos !== e.pos || rev !== e.rev || dir_up !== e.dir || pm !== e.pm || rm !== e.rm) begin
          n_bad++;
          $display("FAIL %s: got pos=%h rev=%h dir=%b pm=%b rm=%b exp pos=%h rev=%h dir=%b pm=%b rm=%b",
                   e.tag, pos, rev, dir_up, pm, rm, e.pos, e.rev, e.dir, e.pm, e.rm);
        end
      end
    end
  end

  task automatic wr(int addr, logic [CNT_W-1:0] data);
    @(negedge clk);
    wr_en = 1; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 0;
    case (addr)
      0: m_cfg = data[7:0];
      1: m_pos = data;
      2: m_rev = data;
      3: m_cpos = data;
      4: m_crev = data;
      5: begin
        if (data[0]) m_pm = 0;
        if (data[1]) m_rm = 0;
      end
      default: ;
    endcase
  endtask

  // apply new input levels and update the model per R2..R10
  task automatic drv(logic na, logic nb, logic nz, string tag, bit lat_chk = 0);
    logic ah, bh, zh, st, up, dnow;
    logic [1:0] md;
    logic [CNT_W-1:0] old_pos;
    old_pos = m_pos;
    ah = qual(pa, na, m_cfg[1:0]);
    bh = qual(pb, nb, m_cfg[3:2]);
    zh = qual(pz, nz, m_cfg[5:4]);
    md = m_cfg[7:6];
    st = 0; up = 1;
    case (md)
      2'b01: begin st = ah ^ bh; up = ah; end
      2'b10: begin st = ah; up = (na != nb); end
      2'b11: begin st = ah ^ bh; up = ah ? (na != nb) : (na == nb); end
      default: ;
    endcase
    if (md == 2'b00) zh = 0;
    dnow = st ? up : m_dir;
    if (zh) begin
      m_pos = 0;
      m_rev = dnow ? m_rev + 1 : m_rev - 1;
      if (m_rev == m_crev) m_rm = 1;
    end else if (st) begin
      m_pos = up ? m_pos + 1 : m_pos - 1;
    end
    if ((zh || st) && m_pos == m_cpos) m_pm = 1;
    if (st) m_dir = up;
    pa = na; pb = nb; pz = nz;
    @(negedge clk);
    a = na; b = nb; z = nz;
    repeat (2) @(posedge clk);
    if (lat_chk) begin
      logic [CNT_W-1:0] new_pos;
      @(negedge clk);
      new_pos = m_pos;
      if (pos !== old_pos) begin
        n_bad++;
        $display("FAIL R3 early update: got pos=%h exp %h", pos, old_pos);
      end
      n_cmp++;
    end
    @(posedge clk);
    @(negedge clk);
    push(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, got no finish, exp finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    push("R1 reset state");

    // R4 up/down, A rise up, B rise down
    wr(0, 16'h0045);
    drv(1, 0, 0, "R4 A rise up", 1);   // R3 latency sampled
    drv(0, 0, 0, "R2 A fall not selected");
    drv(1, 0, 0, "R4 A rise up again");
    drv(0, 0, 0, "R4 idle");
    drv(0, 1, 0, "R4 B rise down");
    drv(0, 0, 0, "R4 idle");
    drv(1, 1, 0, "R4 A and B together no change");
    drv(0, 0, 0, "R4 idle");

    // R2 A on falling edge only
    wr(0, 16'h0046);
    drv(1, 0, 0, "R2 A rise ignored");
    drv(0, 0, 0, "R2 A fall counts");

    // R5 x4 forward, then Z, then reverse
    wr(0, 16'h00DF);
    drv(1, 0, 0, "R5 fwd 1");
    drv(1, 1, 0, "R5 fwd 2");
    drv(0, 1, 0, "R5 fwd 3");
    drv(0, 0, 0, "R5 fwd 4");
    drv(0, 0, 1, "R6 Z up clears pos rev+1");
    drv(0, 0, 0, "R6 Z fall not selected");
    drv(0, 1, 0, "R5 rev 1");
    drv(1, 1, 0, "R5 rev 2");
    drv(1, 1, 1, "R6 Z down rev-1");
    drv(1, 1, 0, "R6 idle");
    drv(0, 0, 0, "R5 A and B together ignored");

    // R5 phase A only
    wr(0, 16'h008F);
    drv(0, 1, 0, "R5 B ignored in A-only");
    drv(1, 1, 0, "R5 A rise with B high down");
    drv(0, 1, 0, "R5 A fall with B high up");

    // R4 stop mode
    wr(0, 16'h003F);
    drv(1, 0, 1, "R4 stop ignores A and Z");
    drv(0, 0, 0, "R4 stop idle");

    // R7, R10 position load and wrap
    wr(0, 16'h0045);
    wr(1, 16'hFFFF);
    push("R7 pos load");
    drv(1, 0, 0, "R10 pos wrap up");
    drv(0, 0, 0, "R10 idle");
    wr(2, 16'h0000);
    push("R7 rev load");

    // R10 revolution wrap down
    wr(0, 16'h00DF);
    drv(0, 1, 0, "R10 down step");
    drv(0, 1, 1, "R10 rev wrap down");
    drv(0, 1, 0, "R10 idle");

    // R8, R9 position compare
    wr(3, 16'h0003);
    wr(0, 16'h0045);
    drv(1, 1, 0, "R8 pos 1");
    drv(0, 1, 0, "R8 idle");
    drv(1, 1, 0, "R8 pos 2");
    drv(0, 1, 0, "R8 idle");
    drv(1, 1, 0, "R8 pos 3 match");
    drv(0, 1, 0, "R9 idle");
    drv(1, 1, 0, "R9 flag sticky");
    wr(5, 16'h0000);
    push("R9 zero clear write no effect");
    wr(5, 16'h0001);
    push("R9 pos flag cleared");
    wr(1, 16'h0003);
    push("R8 load to compare value no flag");

    // R8 revolution compare
    wr(4, 16'h0000);
    wr(0, 16'h00DF);
    drv(1, 1, 1, "R8 rev reaches compare");
    drv(1, 1, 0, "R8 idle");
    wr(5, 16'h0002);
    push("R9 rev flag cleared");

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule